// File: doc/BRIEF.md
# Edge-Latched Interrupt Status Register

This block gathers the interrupt sources of an audio serial port wrapper built around a synchronous serial controller. There are two kinds of source. Three error conditions are captured as sticky flags, and each is captured only when its condition goes from low to high:

- a data-size protocol error on the serial port (any configured size other than 16 bits),
- the same error on an external codec in slave mode,
- a transmit underrun (a transfer starts while the transmit FIFO is empty).

The other four flags come from the inner controller's raw status and pass straight through without any storage: transmit FIFO, receive FIFO, receive timeout and receive overrun.

Software reads the seven flags as a raw status word. It clears the sticky errors by writing ones to a clear register, and chooses through a mask register which flags drive the single interrupt request line. An error whose condition stays high after it has been cleared is not reported again. It is reported again only after the condition falls and then rises.

Top module: `irq_status_reg`

## Requirements
- R1: The status word at byte address 0x0 places the flags as follows: bit 0 receive overrun, bit 1 receive timeout, bit 2 receive FIFO, bit 3 transmit FIFO, bit 4 transmit underrun, bit 5 codec size error, bit 6 serial-port size error. Bits 31:7 of every register read as 0.
- R2: A write to address 0x0 changes neither the status word nor the mask register.
- R3: An error flag (bits 6:4) becomes 1 on the first clock edge at which its condition input is sampled high after having been sampled low.
- R4: Once an error flag is cleared, it stays 0 while its condition stays high. It sets again only after the condition is sampled low and then high.
- R5: Writing to the clear register at address 0xC clears error flag k for each written bit k in 6:4 that is 1. Written zeros leave flags unchanged, and bits 3:0 of the written value have no effect.
- R6: When a rising edge and a clear of the same error flag occur on the same clock edge, the flag ends at 1.
- R7: Bits 3:0 of the status word equal the controller flag inputs in the same cycle, with no register in between.
- R8: After reset the error flags and the mask are 0. With the controller flags at their reset value 4'b1000, the status word reads 0x08 and the interrupt request is 0.
- R9: The mask register at address 0x4 holds bits 6:0 of the last value written there. Address 0x8 reads the status word ANDed with the mask.
- R10: The interrupt request output is the OR of the seven masked status bits.
- R11: The clear register reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W (4) | Byte address of the register being read or written |
| bus_wr_i | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Read data of the addressed register, combinational |
| ssp_size_err_i | input | 1 | Serial-port data-size error condition |
| codec_size_err_i | input | 1 | External codec data-size error condition |
| tx_underrun_i | input | 1 | Transmit underrun condition |
| ctl_flags_i | input | 4 | Controller raw flags: [3] tx FIFO, [2] rx FIFO, [1] rx timeout, [0] rx overrun |
| irq_o | output | 1 | Interrupt request, OR of the masked flags |

## Verification
The assertions check the following on every cycle:
- an error flag only rises after its condition was high;
- a condition held high after a clear never sets the flag again;
- a fresh edge survives a same-cycle clear;
- a clear with the condition low empties the flag;
- a zero mask silences the request;
- the unused upper read bits stay at zero.

Other behaviour can only be shown by the bench's scenarios:
- that the flags occupy the right bit positions;
- that a write to the status address and the low clear bits change nothing;
- that the masked view and the request match for every combination of mask and controller flags.

// File: rtl/irq_stat_pkg.sv
`timescale 1ns/1ps
package irq_stat_pkg;
    localparam int unsigned OFS_RAW  = 'h0;
    localparam int unsigned OFS_MASK = 'h4;
    localparam int unsigned OFS_MSKD = 'h8;
    localparam int unsigned OFS_CLR  = 'hC;

    typedef struct packed {
        logic prev;
        logic flag;
    } edge_state_t;
endpackage

// File: rtl/irq_edge_latch.sv
`timescale 1ns/1ps
module irq_edge_latch
    import irq_stat_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cond_i,
    input  logic clr_i,
    output logic flag_o
);
    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = cond_i;
        st_d.flag = (st_q.flag & ~clr_i) | (cond_i & ~st_q.prev);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    // R3
    rise_needs_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flag_o) |-> $past(cond_i));

    // R4
    held_no_reflag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !flag_o && $past(cond_i) && cond_i) |=> !flag_o);

    // R6
    set_beats_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && cond_i && !$past(cond_i)) |=> flag_o);

    // R5
    clear_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !cond_i) |=> !flag_o);
endmodule

// File: rtl/irq_mask_combine.sv
`timescale 1ns/1ps
module irq_mask_combine #(
    parameter int unsigned W = 7
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] raw_i,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] masked_o,
    output logic         irq_o
);
    always_comb begin
        masked_o = raw_i & mask_i;
        irq_o    = |masked_o;
    end

    // R10
    zero_mask_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_i == '0) |-> !irq_o);
endmodule

// File: rtl/irq_reg_if.sv
`timescale 1ns/1ps
module irq_reg_if
    import irq_stat_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned N_LVL  = 4,
    parameter int unsigned N_ERR  = 3,
    localparam int unsigned W     = N_LVL + N_ERR
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [W-1:0]      wdata_i,
    input  logic [W-1:0]      raw_i,
    input  logic [W-1:0]      masked_i,
    output logic [W-1:0]      mask_o,
    output logic [N_ERR-1:0]  clr_o,
    output logic [DATA_W-1:0] rdata_o
);
    typedef struct packed {
        logic [W-1:0] mask;
    } if_state_t;

    if_state_t st_d, st_q;
    logic sel_raw, sel_mask, sel_mskd, sel_clr;

    always_comb begin
        sel_raw  = addr_i == ADDR_W'(OFS_RAW);
        sel_mask = addr_i == ADDR_W'(OFS_MASK);
        sel_mskd = addr_i == ADDR_W'(OFS_MSKD);
        sel_clr  = addr_i == ADDR_W'(OFS_CLR);

        st_d = st_q;
        if (wr_i && sel_mask) st_d.mask = wdata_i;

        clr_o = (wr_i && sel_clr) ? wdata_i[W-1:N_LVL] : '0;

        rdata_o = '0;
        if (sel_raw)       rdata_o[W-1:0] = raw_i;
        else if (sel_mask) rdata_o[W-1:0] = st_q.mask;
        else if (sel_mskd) rdata_o[W-1:0] = masked_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign mask_o = st_q.mask;

    // R9
    mask_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == ADDR_W'(OFS_MASK)) |=> mask_o == $past(wdata_i));

    // R2
    mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(wr_i && addr_i == ADDR_W'(OFS_MASK))) |=> $stable(mask_o));

    // R1
    upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rdata_o[DATA_W-1:W] == '0);
endmodule

// File: rtl/irq_status_reg.sv
`timescale 1ns/1ps
module irq_status_reg #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned N_LVL  = 4,
    parameter int unsigned N_ERR  = 3,
    localparam int unsigned W     = N_LVL + N_ERR
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              ssp_size_err_i,
    input  logic              codec_size_err_i,
    input  logic              tx_underrun_i,
    input  logic [N_LVL-1:0]  ctl_flags_i,
    output logic              irq_o
);
    logic [N_ERR-1:0] err_cond;
    logic [N_ERR-1:0] err_flag;
    logic [N_ERR-1:0] err_clr;
    logic [W-1:0]     raw;
    logic [W-1:0]     mask;
    logic [W-1:0]     masked;
    logic             unused_wdata_hi;

    assign err_cond        = {ssp_size_err_i, codec_size_err_i, tx_underrun_i};
    assign raw             = {err_flag, ctl_flags_i};
    assign unused_wdata_hi = ^bus_wdata_i[DATA_W-1:W];

    for (genvar k = 0; k < N_ERR; k++) begin : g_err
        irq_edge_latch i_latch (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .cond_i (err_cond[k]),
            .clr_i  (err_clr[k]),
            .flag_o (err_flag[k])
        );
    end

    irq_mask_combine #(.W(W)) i_combine (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .raw_i    (raw),
        .mask_i   (mask),
        .masked_o (masked),
        .irq_o    (irq_o)
    );

    irq_reg_if #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .N_LVL  (N_LVL),
        .N_ERR  (N_ERR)
    ) i_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .addr_i   (bus_addr_i),
        .wr_i     (bus_wr_i),
        .wdata_i  (bus_wdata_i[W-1:0]),
        .raw_i    (raw),
        .masked_i (masked),
        .mask_o   (mask),
        .clr_o    (err_clr),
        .rdata_o  (bus_rdata_o)
    );

    // R7
    live_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_addr_i == ADDR_W'(0)) |-> bus_rdata_o[N_LVL-1:0] == ctl_flags_i);
endmodule

// File: tb/test_irq_status_reg.sv
`timescale 1ns/1ps
module test_irq_status_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  errs = '0;   // [0] underrun, [1] codec, [2] serial port
    logic [3:0]  flags = 4'b1000;
    logic        irq;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    irq_status_reg i_irq_status_reg (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .bus_addr_i       (addr),
        .bus_wr_i         (wr),
        .bus_wdata_i      (wdata),
        .bus_rdata_o      (rdata),
        .ssp_size_err_i   (errs[2]),
        .codec_size_err_i (errs[1]),
        .tx_underrun_i    (errs[0]),
        .ctl_flags_i      (flags),
        .irq_o            (irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R8 reset state
        rd(4'h0, v); check("R8 raw", v, 32'h08);
        rd(4'h4, v); check("R8 mask", v, 32'h0);
        check("R8 irq", {31'd0, irq}, 32'd0);
        // R11
        rd(4'hC, v); check("R11 clr reads 0", v, 32'h0);

        // R7 live mirror, all 16 values
        for (int f = 0; f < 16; f++) begin
            flags = 4'(f);
            rd(4'h0, v); check("R7 mirror", v, 32'(f));
        end
        flags = 4'b0000;

        // R3 R4 R5 per error source
        for (int k = 0; k < 3; k++) begin
            step(); errs[k] = 1'b1;
            step(); rd(4'h0, v); check("R3 set on edge", v, 32'h10 << k);
            // R5 low clear bits and zero bits ignored
            wr_reg(4'hC, 32'h0F | ~(32'h10 << k));
            rd(4'h0, v); check("R5 others ignored", v, 32'h10 << k);
            wr_reg(4'hC, 32'h10 << k);
            rd(4'h0, v); check("R5 clear", v, 32'h0);
            repeat (4) step();
            rd(4'h0, v); check("R4 held not reflagged", v, 32'h0);
            errs[k] = 1'b0;
            step(); rd(4'h0, v); check("R4 fall no flag", v, 32'h0);
            errs[k] = 1'b1;
            step(); rd(4'h0, v); check("R4 rearm", v, 32'h10 << k);
            // R6 edge and clear on same clock
            errs[k] = 1'b0;
            step();
            addr = 4'hC; wdata = 32'h10 << k; wr = 1'b1; errs[k] = 1'b1;
            step(); wr = 1'b0;
            rd(4'h0, v); check("R6 set wins", v, 32'h10 << k);
            errs[k] = 1'b0;
            wr_reg(4'hC, 32'h70);
            rd(4'h0, v); check("R5 clear low cond", v, 32'h0);
        end

        // all three set together
        step(); errs = 3'b111;
        step(); errs = 3'b000;
        step(); rd(4'h0, v); check("R3 all", v, 32'h70);

        // R2 write to status address
        wr_reg(4'h4, 32'h15);
        wr_reg(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, v); check("R2 raw unchanged", v, 32'h70);
        rd(4'h4, v); check("R2 mask unchanged", v, 32'h15);
        // R1 upper bits
        wr_reg(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, v); check("R1 upper zero", v, 32'h7F);

        // R9 R10 exhaustive mask x flags
        for (int m = 0; m < 128; m++) begin
            wr_reg(4'h4, 32'(m));
            rd(4'h4, v); check("R9 mask rb", v, 32'(m));
            for (int f = 0; f < 16; f++) begin
                flags = 4'(f);
                rd(4'h8, v);
                check("R9 masked", v, (32'h70 | 32'(f)) & 32'(m));
                check("R10 irq", {31'd0, irq}, {31'd0, (((32'h70 | 32'(f)) & 32'(m)) != 0)});
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule